// File: doc/BRIEF.md
# Fetch-Execute Control Sequencer

This block is the control unit of a 16-bit accumulator machine. It owns a 16-bit status word that packs a 10-bit program counter under a condition-code field. It also owns the accumulator, the current-instruction register and the memory address and data registers. It runs one instruction cycle after another with no end. First it advances the program counter. It then reads the instruction word at the address just left behind and latches that word. It fetches any operand the addressing mode needs and executes the operation. Every cycle ends with one exception-service step.

The memory sits outside the block and is reached through a single port. An access happens in a cycle where the enable is high, and the read/write select chooses its direction. Memory is synchronous: read data is presented on `mem_rdata` in the cycle after the enable cycle, and a write takes effect at the clock edge that ends the enable cycle. Three operations are decoded: load, store and add. Three addressing modes are decoded: immediate, direct and indirect. Every other encoding completes as a no-op.

Top module: `fex_sequencer`

## Requirements
- R1: `psw_o[9:0]` is the program counter and `psw_o[15:10]` is the condition-code field. The counter advances by exactly one per instruction.
- R2: The increment step comes first. In the next cycle the fetch drives the counter's value minus one onto `mem_addr`, with `mem_en`=1 and `mem_rd`=1. After reset the first fetch reads address 0.
- R3: An instruction word holds the mode in bits 15:13, the operation in bits 12:10 and the operand specifier in bits 9:0. Mode 000 is immediate, which uses the specifier zero-extended. Mode 001 is direct, which uses mem[spec]. Mode 010 is indirect, which uses mem[mem[spec][9:0]]. The fetched word appears on `ci_o` from the cycle after the fetch read.
- R4: Operation 001 (load) places the operand in the accumulator. It sets Z (psw bit 10) and N (psw bit 11) from the value and clears C (bit 12) and V (bit 13).
- R5: Operation 011 (add) adds the operand to the accumulator in two's complement. It sets Z and N from the sum, C to the carry out of bit 15 and V to signed overflow. Psw bits 15:14 read zero.
- R6: Operation 010 (store) writes the accumulator to the effective address (`mem_en`=1, `mem_rd`=0) and changes neither the accumulator nor the condition codes. An immediate store makes no memory access.
- R7: An operation outside {001, 010, 011} or a mode above 010 makes no operand access and leaves the accumulator and the condition codes unchanged.
- R8: The program counter wraps from 1023 to 0, and the fetch that follows 1023 reads address 0.
- R9: The spacing between consecutive fetches, in cycles, is set by the previous instruction, and each figure includes one exception-service cycle: 4 for a no-op or an immediate store, 5 for an immediate load or add, 7 for a direct load or add, 9 for an indirect load or add, 5 for a direct store and 7 for an indirect store. No two memory accesses are in consecutive cycles.
- R10: A synchronous reset clears the status word, the accumulator and the current-instruction register, and it holds `mem_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 10 | Memory address, driven from the address register |
| mem_en | output | 1 | Memory access enable |
| mem_rd | output | 1 | 1 = read, 0 = write |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data, valid the cycle after a read enable |
| psw_o | output | 16 | Status word: condition codes over program counter |
| ac_o | output | 16 | Accumulator |
| ci_o | output | 16 | Current instruction |

## Verification
The bench runs more than one full pass of the address space so that the counter wraps. A design that compared the wrap wrongly would fetch address 1024 truncated to the wrong place, or would stall at 1023. A directed prologue builds the boundary arithmetic cases. The sum 0x7FFF+1 must raise V without C. The sum 0x8000+0xFFFF must raise both C and V. An indirect add that returns to zero must raise Z together with C. A wrong flag equation shows up in the status word at the next fetch. Indirect and immediate stores, together with illegal modes and operations, expose a sequencer that issues a stray access or corrupts the accumulator. Fetch spacing is compared for every instruction, so a missing latch state, a skipped exception-service step or an extra cycle changes the measured gap.

// File: rtl/fex_pkg.sv
`timescale 1ns/1ps
package fex_pkg;

    typedef enum logic [3:0] {
        ST_INC,
        ST_FETCH,
        ST_DECODE,
        ST_PTR,
        ST_PTRLAT,
        ST_READ,
        ST_READLAT,
        ST_WRITE,
        ST_EXEC,
        ST_EXC
    } fex_state_e;

    localparam int FIELD_W  = 3;
    localparam int CC_FLAGS = 4;

    localparam logic [FIELD_W-1:0] MODE_IMM = 3'b000;
    localparam logic [FIELD_W-1:0] MODE_DIR = 3'b001;
    localparam logic [FIELD_W-1:0] MODE_IND = 3'b010;

    localparam logic [FIELD_W-1:0] OP_LOAD  = 3'b001;
    localparam logic [FIELD_W-1:0] OP_STORE = 3'b010;
    localparam logic [FIELD_W-1:0] OP_ADD   = 3'b011;

endpackage

// File: rtl/fex_decode.sv
`timescale 1ns/1ps
module fex_decode
    import fex_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0]  word,
    output logic [FIELD_W-1:0] mode,
    output logic               is_load,
    output logic               is_store,
    output logic               is_add,
    output logic               legal,
    output logic [ADDR_W-1:0]  opspec
);
    localparam int OP_LSB   = ADDR_W;
    localparam int MODE_LSB = ADDR_W + FIELD_W;

    logic [FIELD_W-1:0] op;
    logic               mode_ok;

    assign mode     = word[MODE_LSB +: FIELD_W];
    assign op       = word[OP_LSB +: FIELD_W];
    assign opspec   = word[ADDR_W-1:0];
    assign is_load  = (op == OP_LOAD);
    assign is_store = (op == OP_STORE);
    assign is_add   = (op == OP_ADD);
    assign mode_ok  = (mode == MODE_IMM) || (mode == MODE_DIR) || (mode == MODE_IND);
    assign legal    = (is_load || is_store || is_add) && mode_ok;

endmodule

// File: rtl/fex_alu.sv
`timescale 1ns/1ps
module fex_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic              do_add,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_v
);
    logic [DATA_W:0] sum;

    always_comb begin
        sum = {1'b0, acc} + {1'b0, operand};
        if (do_add) begin
            result = sum[DATA_W-1:0];
            flag_c = sum[DATA_W];
            flag_v = (acc[DATA_W-1] == operand[DATA_W-1]) &&
                     (sum[DATA_W-1] != acc[DATA_W-1]);
        end else begin
            result = operand;
            flag_c = 1'b0;
            flag_v = 1'b0;
        end
        flag_z = (result == '0);
        flag_n = result[DATA_W-1];
    end

endmodule

// File: rtl/fex_sequencer.sv
`timescale 1ns/1ps
module fex_sequencer
    import fex_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] psw_o,
    output logic [DATA_W-1:0] ac_o,
    output logic [DATA_W-1:0] ci_o
);
    localparam int CC_W   = DATA_W - ADDR_W;
    localparam int CC_PAD = CC_W - CC_FLAGS;

    typedef struct packed {
        fex_state_e            state;
        logic [CC_FLAGS-1:0]   cc;     // {V, C, N, Z}
        logic [ADDR_W-1:0]     pc;
        logic [DATA_W-1:0]     ac;
        logic [DATA_W-1:0]     ci;
        logic [DATA_W-1:0]     mdr;
        logic [ADDR_W-1:0]     mar;
    } seq_t;

    seq_t q, d;

    logic [DATA_W-1:0]  dec_word;
    logic [FIELD_W-1:0] dec_mode;
    logic               dec_load, dec_store, dec_add, dec_legal;
    logic [ADDR_W-1:0]  dec_spec;

    logic [DATA_W-1:0]  alu_res;
    logic               alu_z, alu_n, alu_c, alu_v;

    // While the word arrives it is decoded straight off the bus; later from CI.
    assign dec_word = (q.state == ST_DECODE) ? mem_rdata : q.ci;

    fex_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .word     (dec_word),
        .mode     (dec_mode),
        .is_load  (dec_load),
        .is_store (dec_store),
        .is_add   (dec_add),
        .legal    (dec_legal),
        .opspec   (dec_spec)
    );

    fex_alu #(.DATA_W(DATA_W)) u_alu (
        .acc     (q.ac),
        .operand (q.mdr),
        .do_add  (dec_add),
        .result  (alu_res),
        .flag_z  (alu_z),
        .flag_n  (alu_n),
        .flag_c  (alu_c),
        .flag_v  (alu_v)
    );

    always_comb begin
        d         = q;
        mem_en    = 1'b0;
        mem_rd    = 1'b1;
        mem_addr  = q.mar;
        mem_wdata = q.mdr;
        unique case (q.state)
            ST_INC: begin
                d.pc    = q.pc + 1'b1;
                d.mar   = q.pc;            // counter minus one after the step
                d.state = ST_FETCH;
            end
            ST_FETCH: begin
                mem_en  = 1'b1;
                d.state = ST_DECODE;
            end
            ST_DECODE: begin
                d.ci  = mem_rdata;
                d.mar = dec_spec;
                d.mdr = {{CC_W{1'b0}}, dec_spec};
                if (!dec_legal) begin
                    d.state = ST_EXC;
                end else if (dec_mode == MODE_IMM) begin
                    d.state = dec_store ? ST_EXC : ST_EXEC;
                end else if (dec_mode == MODE_DIR) begin
                    if (dec_store) begin
                        d.mdr   = q.ac;
                        d.state = ST_WRITE;
                    end else begin
                        d.state = ST_READ;
                    end
                end else begin
                    d.state = ST_PTR;
                end
            end
            ST_PTR: begin
                mem_en  = 1'b1;
                d.state = ST_PTRLAT;
            end
            ST_PTRLAT: begin
                d.mar = mem_rdata[ADDR_W-1:0];
                if (dec_store) begin
                    d.mdr   = q.ac;
                    d.state = ST_WRITE;
                end else begin
                    d.state = ST_READ;
                end
            end
            ST_READ: begin
                mem_en  = 1'b1;
                d.state = ST_READLAT;
            end
            ST_READLAT: begin
                d.mdr   = mem_rdata;
                d.state = ST_EXEC;
            end
            ST_WRITE: begin
                mem_en  = 1'b1;
                mem_rd  = 1'b0;
                d.state = ST_EXC;
            end
            ST_EXEC: begin
                d.ac    = alu_res;
                d.cc    = {alu_v, alu_c, alu_n, alu_z};
                d.state = ST_EXC;
            end
            ST_EXC: begin
                d.state = ST_INC;          // no exception source is pending
            end
            default: begin
                d.state = ST_INC;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign psw_o = {{CC_PAD{1'b0}}, q.cc, q.pc};
    assign ac_o  = q.ac;
    assign ci_o  = q.ci;

endmodule

// File: rtl/fex_sequencer_chk.sv
`timescale 1ns/1ps
module fex_sequencer_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_en,
    input logic              mem_rd,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] psw_o,
    input logic [DATA_W-1:0] ac_o,
    input logic [DATA_W-1:0] ci_o
);
    logic [ADDR_W-1:0] pc_now;
    assign pc_now = psw_o[ADDR_W-1:0];

    // R1: a counter change is always a single step, modulo the address space
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        (pc_now != $past(pc_now)) |-> (pc_now == ADDR_W'($past(pc_now) + 1'b1)));

    // R2: the cycle where the counter has just moved is a read of counter minus one
    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_now != $past(pc_now)) |->
            (mem_en && mem_rd && (mem_addr == ADDR_W'(pc_now - 1'b1))));

    // R6: write data equals the accumulator the store reads
    assert_store_data_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_rd) |-> (mem_wdata == ac_o));

    // R9: each access is followed by a cycle without one
    assert_access_gap_R9: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> !mem_en);

    // R10: after a reset edge the visible state is cleared and the port is idle
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (psw_o == '0 && ac_o == '0 && ci_o == '0 && !mem_en));

endmodule

bind fex_sequencer fex_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_en    (mem_en),
    .mem_rd    (mem_rd),
    .mem_wdata (mem_wdata),
    .psw_o     (psw_o),
    .ac_o      (ac_o),
    .ci_o      (ci_o)
);

// File: tb/tb_fex_sequencer.sv
`timescale 1ns/1ps
module tb_fex_sequencer;

    localparam int AW     = 10;
    localparam int DW     = 16;
    localparam int DEPTH  = 1 << AW;
    localparam int N_INSN = 1100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_en, mem_rd;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] psw_o, ac_o, ci_o;

    always #2 clk = ~clk;   // 4 ns period

    fex_sequencer #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_en(mem_en), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .psw_o(psw_o), .ac_o(ac_o), .ci_o(ci_o)
    );

    // kind: 0 fetch, 1 operand/pointer read, 2 write
    typedef struct {
        int kind;
        int addr;
        int data;
        int psw;
        int ac;
        int ci;
        int gap;
        int prev_nop;
    } ev_t;

    ev_t sb[$];
    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    function automatic logic [15:0] prog_word(input int a);
        int unsigned h;
        case (a)
            0:    return 16'h0400;   // load #0
            1:    return 16'h2FE8;   // add [1000]
            2:    return 16'h0C01;   // add #1
            3:    return 16'h2FEA;   // add [1002]
            4:    return 16'h2BF2;   // store [1010]
            5:    return 16'h47EC;   // load @[1004]
            6:    return 16'h4FEC;   // add @[1004]
            7:    return 16'h4BED;   // store @[1005]
            8:    return 16'h0805;   // store #5
            9:    return 16'h6C01;   // illegal mode
            10:   return 16'h1C01;   // illegal operation
            11:   return 16'h27F2;   // load [1010]
            12:   return 16'h2FEB;   // add [1003]
            1000: return 16'h7FFF;
            1001: return 16'h8000;
            1002: return 16'hFFFF;
            1003: return 16'h0001;
            1004: return 16'h03E9;
            1005: return 16'h03F3;
            default: begin
                h = a * 32'h9E3779B1;
                h = h ^ (h >> 15);
                h = h * 32'h85EBCA6B;
                h = h ^ (h >> 13);
                return {1'b0, h[14:0]};
            end
        endcase
    endfunction

    // memory responder
    initial begin
        logic [DW-1:0] mem [DEPTH];
        for (int a = 0; a < DEPTH; a++) mem[a] = prog_word(a);
        forever begin
            @(posedge clk);
            if (mem_en) begin
                if (mem_rd) mem_rdata <= mem[mem_addr];
                else        mem[mem_addr] <= mem_wdata;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: reference execution pushes the expected bus and state items
    task automatic build(input int n);
        logic [15:0] rm [DEPTH];
        logic [AW-1:0] pc, a, ea, os;
        logic [15:0] ac, ci, w, opnd, res;
        logic [16:0] sum;
        logic [3:0] cc;
        logic [2:0] mode, op;
        int prev_len, prev_nop;
        bit ok;
        ev_t e;
        for (int i = 0; i < DEPTH; i++) rm[i] = prog_word(i);
        pc = '0; ac = '0; ci = '0; cc = '0; prev_len = 0; prev_nop = 0;
        for (int i = 0; i < n; i++) begin
            a  = pc;
            pc = pc + 1'b1;
            e = '{0, int'(a), 0, int'({2'b00, cc, pc}), int'(ac), int'(ci), prev_len, prev_nop};
            sb.push_back(e);
            w = rm[a]; ci = w;
            mode = w[15:13]; op = w[12:10]; os = w[9:0];
            ok = (op == 3'd1 || op == 3'd2 || op == 3'd3) && (mode <= 3'd2);
            prev_nop = ok ? 0 : 1;
            if (!ok) begin
                prev_len = 4;
            end else begin
                ea = os;
                if (mode == 3'd2) begin
                    e = '{1, int'(os), 0, 0, 0, 0, 0, 0};
                    sb.push_back(e);
                    ea = rm[os][AW-1:0];
                end
                if (op == 3'd2) begin
                    if (mode == 3'd0) begin
                        prev_len = 4;
                    end else begin
                        e = '{2, int'(ea), int'(ac), 0, 0, 0, 0, 0};
                        sb.push_back(e);
                        rm[ea] = ac;
                        prev_len = (mode == 3'd1) ? 5 : 7;
                    end
                end else begin
                    if (mode == 3'd0) begin
                        opnd = {6'b0, os};
                    end else begin
                        e = '{1, int'(ea), 0, 0, 0, 0, 0, 0};
                        sb.push_back(e);
                        opnd = rm[ea];
                    end
                    if (op == 3'd1) begin
                        res = opnd;
                        cc  = {1'b0, 1'b0, res[15], res == 16'h0};
                    end else begin
                        sum = {1'b0, ac} + {1'b0, opnd};
                        res = sum[15:0];
                        cc  = {(ac[15] == opnd[15]) && (res[15] != ac[15]), sum[16],
                               res[15], res == 16'h0};
                    end
                    ac = res;
                    prev_len = (mode == 3'd0) ? 5 : ((mode == 3'd1) ? 7 : 9);
                end
            end
        end
    endtask

    // monitor: pops and compares as the design issues memory accesses
    int cyc = 0;
    int last_fetch = 0;
    int n_fetch = 0;
    always @(negedge clk) begin
        ev_t e;
        if (!rst && !done) begin
            cyc++;
            if (mem_en) begin
                if (sb.size() == 0) begin
                    done = 1'b1;
                end else begin
                    e = sb.pop_front();
                    if (e.kind == 0) begin
                        check("R2", "fetch read select", int'(mem_rd), 1);
                        check((e.addr == 0 && n_fetch > 0) ? "R8" : "R2", "fetch addr",
                              int'(mem_addr), e.addr);
                        check("R1", "pc", int'(psw_o[9:0]), e.psw & 16'h03FF);
                        check(e.prev_nop != 0 ? "R7" : "R5", "cc field",
                              int'(psw_o[15:10]), e.psw >> 10);
                        check(e.prev_nop != 0 ? "R7" : "R4", "accumulator", int'(ac_o), e.ac);
                        check("R3", "current instruction", int'(ci_o), e.ci);
                        if (n_fetch > 0)
                            check("R9", "fetch spacing", cyc - last_fetch, e.gap);
                        last_fetch = cyc;
                        n_fetch++;
                    end else if (e.kind == 1) begin
                        check("R3", "operand read select", int'(mem_rd), 1);
                        check("R3", "operand addr", int'(mem_addr), e.addr);
                    end else begin
                        check("R6", "store select", int'(mem_rd), 0);
                        check("R6", "store addr", int'(mem_addr), e.addr);
                        check("R6", "store data", int'(mem_wdata), e.data);
                    end
                    if (sb.size() == 0) done = 1'b1;
                end
            end
        end
    end

    initial begin
        build(N_INSN);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "psw in reset", int'(psw_o), 0);
        check("R10", "acc in reset", int'(ac_o), 0);
        check("R10", "ci in reset", int'(ci_o), 0);
        check("R10", "enable in reset", int'(mem_en), 0);
        rst = 1'b0;
        fork
            wait (done);
            repeat (100000) @(posedge clk);
        join_any
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", sb.size(), 0);
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule